// File: doc/BRIEF.md
# Full-Scale Gain Calibration Sequencer

This block steers the digital back end of a delta-sigma converter through a one-command gain calibration. When a start request arrives with the gain-calibration command code, it runs three conversions in turn. The first conversion uses the differential input as applied, and its result is written to the negative full-scale register. Before the second conversion the sequencer reverses the input polarity internally, and that result is written to the positive full-scale register. Polarity then goes back to normal and one more conversion period elapses. At the end of that period the data-ready flag rises.

The conversion itself happens outside the block. The sequencer issues a one-cycle request for each conversion and then waits for a one-cycle completion pulse that carries the result. The register writes leave the block as one-cycle write enables that share a single data bus. The reserved command code, and every code other than the calibration code, is a defined no-op.

Top module: `gaincal_seq`

## Requirements
- R1: A start pulse with command code 3'b110, seen while `busy` is low, raises `busy` on the next cycle, pulses `conv_go` high for exactly that one cycle, and clears `drdy` in that same cycle. One calibration issues exactly three `conv_go` pulses.
- R2: The first completion (`conv_done` high) after the start produces a one-cycle `neg_fs_we` pulse. `pol_swap` is low for the whole of the first conversion.
- R3: The second completion produces a one-cycle `pos_fs_we` pulse. `pol_swap` is high from the cycle of the second `conv_go` until that completion, and low again in the cycle of the `pos_fs_we` pulse.
- R4: After the positive store a third conversion is requested with `pol_swap` low. `drdy` rises, and `busy` falls, in the cycle after that third completion.
- R5: In a write-enable cycle, `fs_wdata` carries the full 24-bit `conv_result` that came with the completion one cycle earlier, unchanged.
- R6: A start pulse with the reserved code 3'b111, or with any other code that is not 3'b110, has no effect. `busy` and `conv_go` stay low and `drdy` keeps its value.
- R7: A start pulse while `busy` is high is ignored. It causes no extra `conv_go` and does not restart the sequence.
- R8: A synchronous reset returns the block to idle. In the cycle after reset, `busy`, `drdy`, `pol_swap`, `conv_go` and both write enables are low, and no write follows.
- R9: A `conv_done` pulse while `busy` is low causes no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_start | input | 1 | Command strobe, one cycle |
| cal_mode | input | 3 | Command code sampled with the strobe |
| conv_done | input | 1 | Conversion complete, one cycle |
| conv_result | input | 24 | Result that accompanies `conv_done` |
| conv_go | output | 1 | Request for one conversion, one cycle |
| pol_swap | output | 1 | High while the input polarity is reversed |
| neg_fs_we | output | 1 | Write enable for the negative full-scale register |
| pos_fs_we | output | 1 | Write enable for the positive full-scale register |
| fs_wdata | output | 24 | Data for either full-scale register |
| busy | output | 1 | Calibration in progress |
| drdy | output | 1 | Calibration complete, data valid |

## Verification
The bench builds the block with its default parameters: a 24-bit data path, calibration code 6 and reserved code 7. The full width is therefore exercised with all-ones, all-zeros and single-top-bit patterns. The conversion stub's latency is swept from one cycle up to nine. The one-cycle setting puts each completion directly after its request, and the longer settings leave room for a second start, and for a reset, to land in the middle of the polarity-swapped conversion.

// File: rtl/gaincal_seq.sv
module gaincal_seq #(
  parameter int DATA_W = 24,
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] CAL_CODE = MODE_W'(6),
  parameter logic [MODE_W-1:0] RSV_CODE = MODE_W'(7)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic [MODE_W-1:0] cal_mode,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result,
  output logic              conv_go,
  output logic              pol_swap,
  output logic              neg_fs_we,
  output logic              pos_fs_we,
  output logic [DATA_W-1:0] fs_wdata,
  output logic              busy,
  output logic              drdy
);

  typedef enum logic [1:0] {S_IDLE, S_NEG, S_POS, S_SETTLE} phase_t;
  phase_t phase;

  wire accept = cal_start && (cal_mode == CAL_CODE) && (phase == S_IDLE);

  assign busy = (phase != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= S_IDLE;
      conv_go   <= 1'b0;
      pol_swap  <= 1'b0;
      neg_fs_we <= 1'b0;
      pos_fs_we <= 1'b0;
      fs_wdata  <= '0;
      drdy      <= 1'b0;
    end else begin
      conv_go   <= 1'b0;
      neg_fs_we <= 1'b0;
      pos_fs_we <= 1'b0;
      case (phase)
        S_IDLE: if (accept) begin
          phase    <= S_NEG;
          conv_go  <= 1'b1;
          pol_swap <= 1'b0;
          drdy     <= 1'b0;
        end
        S_NEG: if (conv_done) begin
          phase     <= S_POS;
          neg_fs_we <= 1'b1;
          fs_wdata  <= conv_result;
          pol_swap  <= 1'b1;
          conv_go   <= 1'b1;
        end
        S_POS: if (conv_done) begin
          phase     <= S_SETTLE;
          pos_fs_we <= 1'b1;
          fs_wdata  <= conv_result;
          pol_swap  <= 1'b0;
          conv_go   <= 1'b1;
        end
        S_SETTLE: if (conv_done) begin
          phase <= S_IDLE;
          drdy  <= 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gaincal_seq_chk.sv
module gaincal_seq_chk #(
  parameter int DATA_W = 24,
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] CAL_CODE = MODE_W'(6),
  parameter logic [MODE_W-1:0] RSV_CODE = MODE_W'(7)
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_start,
  input logic [MODE_W-1:0] cal_mode,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_result,
  input logic              conv_go,
  input logic              pol_swap,
  input logic              neg_fs_we,
  input logic              pos_fs_we,
  input logic [DATA_W-1:0] fs_wdata,
  input logic              busy,
  input logic              drdy
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q)
      a_r8_reset_idle: assert (!busy && !drdy && !pol_swap && !conv_go && !neg_fs_we && !pos_fs_we);

  a_r1_start_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && cal_start && cal_mode == CAL_CODE) |=> (busy && conv_go && !drdy));

  a_r2_neg_normal: assert property (@(posedge clk) disable iff (rst)
    neg_fs_we |-> (pol_swap && !$past(pol_swap)));

  a_r3_pos_swapped: assert property (@(posedge clk) disable iff (rst)
    pos_fs_we |-> ($past(pol_swap) && !pol_swap));

  a_r4_drdy_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy) |-> ($past(conv_done) && $past(busy) && !busy));

  a_r5_wdata_pass: assert property (@(posedge clk) disable iff (rst)
    (neg_fs_we || pos_fs_we) |-> (fs_wdata == $past(conv_result)));

  a_r6_reserved_noop: assert property (@(posedge clk) disable iff (rst)
    (!busy && cal_start && cal_mode == RSV_CODE) |=> (!busy && !conv_go));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> !conv_go);

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (!neg_fs_we && !pos_fs_we));

endmodule

bind gaincal_seq gaincal_seq_chk #(
  .DATA_W(DATA_W), .MODE_W(MODE_W), .CAL_CODE(CAL_CODE), .RSV_CODE(RSV_CODE)
) chk_i (.*);

// File: tb/gaincal_seq_tb_top.sv
`timescale 1ns/1ps
module gaincal_seq_tb_top;
  localparam int DW = 24;
  localparam logic [23:0] MASK = 24'hFFFFFF;

  logic clk = 0, rst = 1, cal_start = 0, conv_done = 0;
  logic [2:0] cal_mode = 0;
  logic [DW-1:0] conv_result = 0;
  logic conv_go, pol_swap, neg_fs_we, pos_fs_we, busy, drdy;
  logic [DW-1:0] fs_wdata;

  always #10 clk = ~clk;

  gaincal_seq dut_i (.*);

  int total = 0, bad = 0;
  int lat = 1, cnt = 0, fix_idx = 0;
  bit force_done = 0, started = 0;
  int go_n = 0, nwe_n = 0, pwe_n = 0;
  logic [DW-1:0] fixed [4] = '{24'hFFFFFF, 24'h000000, 24'h800000, 24'h7FFFFF};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // conversion stub
  always @(negedge clk) begin
    conv_done = 0;
    if (rst) cnt = 0;
    else if (force_done) begin
      conv_done = 1; conv_result = DW'($urandom) & MASK;
    end else if (conv_go) cnt = lat;
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done = 1;
        if (fix_idx < 4) begin conv_result = fixed[fix_idx]; fix_idx++; end
        else conv_result = DW'($urandom) & MASK;
      end
    end
  end

  // pulse counters
  always @(posedge clk) begin
    #1;
    if (conv_go) go_n++;
    if (neg_fs_we) nwe_n++;
    if (pos_fs_we) pwe_n++;
  end

  // behavioural reference
  int ph = 0;
  bit e_go = 0, e_pol = 0, e_nwe = 0, e_pwe = 0, e_drdy = 0;
  logic [DW-1:0] e_wd = 0;
  always @(posedge clk) begin
    started <= 1;
    e_go <= 0; e_nwe <= 0; e_pwe <= 0;
    if (rst) begin
      ph <= 0; e_pol <= 0; e_drdy <= 0;
    end else if (ph == 0) begin
      if (cal_start && cal_mode == 3'd6) begin
        ph <= 1; e_go <= 1; e_pol <= 0; e_drdy <= 0;
      end
    end else if (conv_done) begin
      if (ph == 1) begin e_nwe <= 1; e_wd <= conv_result; e_pol <= 1; e_go <= 1; ph <= 2; end
      else if (ph == 2) begin e_pwe <= 1; e_wd <= conv_result; e_pol <= 0; e_go <= 1; ph <= 3; end
      else begin e_drdy <= 1; ph <= 0; end
    end
  end

  always @(negedge clk) if (started) begin
    chk(busy == (ph != 0), "R1 busy", busy, ph != 0);
    chk(conv_go == e_go, "R1 conv_go", conv_go, e_go);
    chk(neg_fs_we == e_nwe, "R2 neg_fs_we", neg_fs_we, e_nwe);
    chk(pos_fs_we == e_pwe, "R3 pos_fs_we", pos_fs_we, e_pwe);
    chk(pol_swap == e_pol, "R3 pol_swap", pol_swap, e_pol);
    chk(drdy == e_drdy, "R4 drdy", drdy, e_drdy);
    if (e_nwe || e_pwe) chk(fs_wdata == e_wd, "R5 fs_wdata", fs_wdata, e_wd);
  end

  task automatic pulse_start(input logic [2:0] m);
    cal_mode = m; cal_start = 1;
    @(negedge clk); cal_start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  int g0, n0, p0;
  task automatic snap(); g0 = go_n; n0 = nwe_n; p0 = pwe_n; endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !drdy && !pol_swap, "R8 reset state", {busy, drdy, pol_swap}, 0);
    rst = 0;
    @(negedge clk);

    // full calibration, latency 1, boundary data
    lat = 1; snap();
    pulse_start(3'd6);
    wait_idle();
    chk(drdy == 1, "R4 drdy after cal", drdy, 1);
    chk(go_n - g0 == 3, "R1 three conversions", go_n - g0, 3);
    chk(nwe_n - n0 == 1, "R2 one negative store", nwe_n - n0, 1);
    chk(pwe_n - p0 == 1, "R3 one positive store", pwe_n - p0, 1);

    // reserved code and other code
    snap();
    pulse_start(3'd7);
    chk(!busy && !conv_go, "R6 reserved no start", {busy, conv_go}, 0);
    chk(drdy == 1, "R6 reserved keeps drdy", drdy, 1);
    pulse_start(3'd2);
    repeat (3) @(negedge clk);
    chk(go_n == g0 && !busy && drdy, "R6 other code no-op", go_n - g0, 0);

    // restart attempt while busy
    lat = 5; snap();
    pulse_start(3'd6);
    repeat (8) @(negedge clk);
    pulse_start(3'd6);
    wait_idle();
    chk(go_n - g0 == 3, "R7 restart ignored", go_n - g0, 3);
    chk(drdy == 1, "R7 sequence completed", drdy, 1);

    // completion while idle
    snap();
    force_done = 1; @(negedge clk); force_done = 0;
    repeat (3) @(negedge clk);
    chk(nwe_n == n0 && pwe_n == p0, "R9 idle done no write", nwe_n - n0 + pwe_n - p0, 0);

    // reset in the swapped conversion
    lat = 4; snap();
    pulse_start(3'd6);
    repeat (6) @(negedge clk);
    chk(pol_swap == 1, "R3 swapped before reset", pol_swap, 1);
    rst = 1; @(negedge clk); rst = 0;
    chk(!busy && !pol_swap && !drdy && !conv_go, "R8 reset mid-sequence",
        {busy, pol_swap, drdy, conv_go}, 0);
    repeat (20) @(negedge clk);
    chk(pwe_n == p0, "R8 no write after reset", pwe_n - p0, 0);

    // latency sweep with random data
    for (int l = 2; l <= 9; l++) begin
      lat = l; snap();
      pulse_start(3'd6);
      wait_idle();
      chk(drdy == 1 && go_n - g0 == 3, "R4 sweep complete", go_n - g0, 3);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule